// File: doc/BRIEF.md
# Prefixed Rotate and Shift Execution Unit

This block executes the rotate, shift and nibble-exchange group of an 8-bit processor's prefixed instruction page. A controller presents a secondary opcode together with a one-cycle `start` strobe, the current accumulator value, the 16-bit pointer register value and the current carry flag. The unit returns the result byte and the zero, subtract, half-carry and carry flags. It signals completion with a one-cycle `done` pulse.

When the opcode names the accumulator, the operation completes in one cycle. When the opcode names the byte addressed by the pointer, the unit reads that byte through a simple synchronous memory port with one cycle of read latency. It transforms the byte and writes it back to the same address, so one instruction takes a read cycle, a write cycle and a completion cycle. All operands are captured at `start`. Result and flags change only in the completion cycle and otherwise hold their last values.

Top module: `rotshift_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are 0, and `result` and all four flags are 0.
- R2: An opcode is accepted only when bits 7:6 are 00. Bits 5:3 select the operation: 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SWAP, 7 SRL. Bits 2:0 select the operand: 7 is the accumulator and 6 is the pointer-addressed byte. The accumulator forms are therefore 0x07, 0x0F, 0x17, 0x1F, 0x27, 0x2F, 0x37 and 0x3F.
- R3: RLC rotates left and copies old bit 7 into bit 0 and into carry. RRC rotates right and copies old bit 0 into bit 7 and into carry.
- R4: RL shifts left, puts the incoming carry into bit 0 and old bit 7 into carry. RR shifts right, puts the incoming carry into bit 7 and old bit 0 into carry.
- R5: SLA shifts left with 0 into bit 0 and old bit 7 into carry. SRA shifts right, keeps bit 7 and puts old bit 0 into carry. SRL shifts right with 0 into bit 7 and old bit 0 into carry.
- R6: SWAP exchanges the high and low nibbles and clears carry.
- R7: On completion, the zero flag is 1 exactly when the result byte is 0, and the subtract and half-carry flags are 0.
- R8: For an accumulator form, `done` is high for exactly the one cycle after the `start` cycle, with the new result and flags visible in that cycle, and no memory access is made.
- R9: For the pointer form, `mem_rd_en` is high for one cycle at the pointer address in the cycle after `start`. In the next cycle `mem_wr_en` is high for one cycle at the same address with the result byte on `mem_wdata`. `done` follows one cycle later, and exactly one write is issued.
- R10: A `start` with an opcode that is not accepted (bits 7:6 nonzero, or operand field 0 to 5) is ignored: `busy` and `done` stay 0, no memory access happens, and `result` and flags keep their values.
- R11: A `start` while `busy` is high is ignored, and the running instruction completes with the operands captured at its own `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that issues `opcode` |
| opcode | input | 8 | Secondary opcode |
| acc_in | input | 8 | Accumulator value |
| hl_in | input | 16 | Pointer register value (memory operand address) |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Result byte of the last completed instruction |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Subtract flag |
| flag_h | output | 1 | Half-carry flag |
| flag_c | output | 1 | Carry flag |
| mem_addr | output | 16 | Memory address |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd_en` |

## Verification
Every cycle, the assertions check the following: the write of a pointer-form instruction directly follows its read at the same address, `done` never lasts two cycles, a rejected opcode leaves the unit idle, the zero flag agrees with the completed result, and SWAP completes with carry cleared. Only the bench's scenarios show the actual bit movement of each operation against its reference model, including the role of the incoming carry and the sign bit. The same applies to the memory contents after write-back, the single-write count, and the operands captured at `start` surviving a second `start` issued mid-instruction.

// File: rtl/rotshift_pkg.sv
// Package: shared types for the prefixed rotate/shift unit.
// Assumes: operation field is 3 bits, operand field is 3 bits.
package rotshift_pkg;

    typedef enum logic [2:0] {
        OP_RLC  = 3'd0,
        OP_RRC  = 3'd1,
        OP_RL   = 3'd2,
        OP_RR   = 3'd3,
        OP_SLA  = 3'd4,
        OP_SRA  = 3'd5,
        OP_SWAP = 3'd6,
        OP_SRL  = 3'd7
    } rs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } rs_state_e;

    localparam logic [2:0] SRC_MEM = 3'd6;
    localparam logic [2:0] SRC_ACC = 3'd7;

endpackage

// File: rtl/rotshift_decode.sv
// Module: opcode decoder.
// Splits the secondary opcode into operation and operand fields and
// flags which operand forms this unit accepts.
// Assumes: only the page with bits 7:6 == 00 belongs to this unit.
module rotshift_decode
    import rotshift_pkg::*;
(
    input  logic [7:0] opcode,
    output rs_op_e     op,
    output logic       is_acc,
    output logic       is_mem
);

    logic page_ok;

    // Field extraction and operand classification.
    always_comb begin
        page_ok = (opcode[7:6] == 2'b00);
        op      = rs_op_e'(opcode[5:3]);
        is_acc  = page_ok && (opcode[2:0] == SRC_ACC);
        is_mem  = page_ok && (opcode[2:0] == SRC_MEM);
    end

endmodule

// File: rtl/rotshift_alu.sv
// Module: combinational rotate/shift/swap datapath.
// Produces the result byte and the outgoing carry for one operation.
// Assumes: DATA_W is even so the swap halves are equal.
module rotshift_alu
    import rotshift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rs_op_e              op,
    input  logic [DATA_W-1:0]   din,
    input  logic                cin,
    output logic [DATA_W-1:0]   dout,
    output logic                cout
);

    localparam int HALF = DATA_W / 2;
    localparam int MSB  = DATA_W - 1;

    // Per-operation bit movement and carry selection.
    always_comb begin
        dout = din;
        cout = 1'b0;
        unique case (op)
            OP_RLC:  begin dout = {din[MSB-1:0], din[MSB]}; cout = din[MSB]; end
            OP_RRC:  begin dout = {din[0], din[MSB:1]};     cout = din[0];   end
            OP_RL:   begin dout = {din[MSB-1:0], cin};      cout = din[MSB]; end
            OP_RR:   begin dout = {cin, din[MSB:1]};        cout = din[0];   end
            OP_SLA:  begin dout = {din[MSB-1:0], 1'b0};     cout = din[MSB]; end
            OP_SRA:  begin dout = {din[MSB], din[MSB:1]};   cout = din[0];   end
            OP_SWAP: begin dout = {din[HALF-1:0], din[MSB:HALF]}; cout = 1'b0; end
            OP_SRL:  begin dout = {1'b0, din[MSB:1]};       cout = din[0];   end
            default: begin dout = din; cout = 1'b0; end
        endcase
    end

endmodule

// File: rtl/rotshift_seq.sv
// Module: instruction sequencer.
// Idle -> done for accumulator forms; idle -> read -> write -> done for
// the memory form. Ignores start outside idle and for rejected opcodes.
// Assumes: memory read data is valid one cycle after the read request.
module rotshift_seq
    import rotshift_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      is_acc,
    input  logic      is_mem,
    output rs_state_e state,
    output logic      capture,
    output logic      load_res
);

    rs_state_e nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start && is_acc) nxt = ST_DONE;
                      else if (start && is_mem) nxt = ST_READ;
            ST_READ:  nxt = ST_WRITE;
            ST_WRITE: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Strobes for operand capture and result loading.
    always_comb begin
        capture  = (state == ST_IDLE) && start && (is_acc || is_mem);
        load_res = ((state == ST_IDLE) && start && is_acc) || (state == ST_WRITE);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // R10: a rejected opcode leaves the sequencer idle.
    a_r10_reject_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !is_acc && !is_mem) |=> (state == ST_IDLE));

    // R9: the write state is always entered straight from the read state.
    a_r9_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> ($past(state) == ST_READ));

endmodule

// File: rtl/rotshift_unit.sv
// Module: top of the prefixed rotate/shift execution unit.
// Captures operands at start, runs one shared datapath either on the
// accumulator (same cycle) or on memory read data (write cycle), and
// registers result and flags in the completion cycle.
// Assumes: synchronous memory port, one-cycle read latency.
module rotshift_unit
    import rotshift_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [ADDR_W-1:0] hl_in,
    input  logic              carry_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_h,
    output logic              flag_c,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    rs_op_e            dec_op;
    logic              dec_acc;
    logic              dec_mem;
    rs_state_e         state;
    logic              capture;
    logic              load_res;
    rs_op_e            op_q;
    logic              cin_q;
    logic [ADDR_W-1:0] addr_q;
    rs_op_e            alu_op;
    logic [DATA_W-1:0] alu_in;
    logic              alu_cin;
    logic [DATA_W-1:0] alu_out;
    logic              alu_cout;
    logic              in_write;

    rotshift_decode u_dec (
        .opcode (opcode),
        .op     (dec_op),
        .is_acc (dec_acc),
        .is_mem (dec_mem)
    );

    rotshift_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_acc   (dec_acc),
        .is_mem   (dec_mem),
        .state    (state),
        .capture  (capture),
        .load_res (load_res)
    );

    // Datapath source select: live inputs at start, captured ones in write.
    always_comb begin
        in_write = (state == ST_WRITE);
        alu_op   = in_write ? op_q  : dec_op;
        alu_in   = in_write ? mem_rdata : acc_in;
        alu_cin  = in_write ? cin_q : carry_in;
    end

    rotshift_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (alu_op),
        .din  (alu_in),
        .cin  (alu_cin),
        .dout (alu_out),
        .cout (alu_cout)
    );

    // Operand capture at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_RLC;
            cin_q  <= 1'b0;
            addr_q <= '0;
        end else if (capture) begin
            op_q   <= dec_op;
            cin_q  <= carry_in;
            addr_q <= hl_in;
        end
    end

    // Result and flag registers, updated only on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
        end else if (load_res) begin
            result <= alu_out;
            flag_z <= (alu_out == '0);
            flag_c <= alu_cout;
        end
    end

    // Port decode from the sequencer state.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        mem_rd_en = (state == ST_READ);
        mem_wr_en = in_write;
        mem_addr  = addr_q;
        mem_wdata = alu_out;
        flag_n    = 1'b0;
        flag_h    = 1'b0;
    end

    // R8: completion is a single-cycle pulse.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: write-back targets the address that was read.
    a_r9_same_address: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));

    // R7: zero flag agrees with the completed result.
    a_r7_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (result == '0)));

    // R6: a completed SWAP leaves carry cleared.
    a_r6_swap_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(load_res) && $past(alu_op) == OP_SWAP) |-> !flag_c);

endmodule

// File: tb/rotshift_unit_test.sv
// Bench: behavioural reference model of each operation and the cycle
// sequence, compared at every negative clock edge.
module rotshift_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  acc_in = 8'h00;
    logic [15:0] hl_in = 16'h0000;
    logic        carry_in = 1'b0;
    logic        busy, done, flag_z, flag_n, flag_h, flag_c;
    logic [7:0]  result;
    logic [15:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    logic [7:0]  mem [0:255];
    int          wr_count = 0;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    rotshift_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .acc_in(acc_in), .hl_in(hl_in), .carry_in(carry_in),
        .busy(busy), .done(done), .result(result),
        .flag_z(flag_z), .flag_n(flag_n), .flag_h(flag_h), .flag_c(flag_c),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: registered read, write on request.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr_en) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_count = wr_count + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model written with integer arithmetic.
    task automatic ref_op(input int op, input int v, input int cin, output int r, output int c);
        case (op)
            0: begin c = v / 128; r = (v * 2) % 256 + c; end
            1: begin c = v % 2;   r = v / 2 + c * 128; end
            2: begin c = v / 128; r = (v * 2) % 256 + cin; end
            3: begin c = v % 2;   r = v / 2 + cin * 128; end
            4: begin c = v / 128; r = (v * 2) % 256; end
            5: begin c = v % 2;   r = v / 2 + (v / 128) * 128; end
            6: begin c = 0;       r = (v % 16) * 16 + v / 16; end
            default: begin c = v % 2; r = v / 2; end
        endcase
    endtask

    function automatic string op_req(input int op);
        case (op)
            0, 1: return "R3";
            2, 3: return "R4";
            6:    return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic check_flags(input string req, input int r, input int c);
        chk(req, "result", int'(result), r);
        chk(req, "carry", int'(flag_c), c);
        chk("R7", "zero", int'(flag_z), (r == 0) ? 1 : 0);
        chk("R7", "sub", int'(flag_n), 0);
        chk("R7", "half", int'(flag_h), 0);
    endtask

    task automatic run_acc(input int op, input logic [7:0] a, input logic cin);
        int r, c;
        ref_op(op, int'(a), int'(cin), r, c);
        @(negedge clk);
        opcode = {2'b00, op[2:0], 3'b111}; acc_in = a; carry_in = cin; start = 1'b1;
        @(negedge clk);
        start = 1'b0; acc_in = ~a; carry_in = ~cin;
        chk("R8", "done", int'(done), 1);
        chk("R8", "mem access", int'(mem_rd_en | mem_wr_en), 0);
        check_flags(op_req(op), r, c);
        @(negedge clk);
        chk("R8", "done after", int'(done), 0);
        chk("R8", "busy after", int'(busy), 0);
    endtask

    task automatic run_mem(input int op, input logic [15:0] hl, input logic [7:0] v,
                           input logic cin, input bit poke);
        int r, c;
        ref_op(op, int'(v), int'(cin), r, c);
        mem[hl[7:0]] = v;
        wr_count = 0;
        @(negedge clk);
        opcode = {2'b00, op[2:0], 3'b110}; hl_in = hl; carry_in = cin; acc_in = 8'hFF;
        start = 1'b1;
        @(negedge clk);
        if (poke) begin
            opcode = 8'h07; acc_in = 8'h00; hl_in = hl + 16'd1; carry_in = ~cin;
        end else start = 1'b0;
        chk("R9", "rd_en", int'(mem_rd_en), 1);
        chk("R9", "wr_en in read", int'(mem_wr_en), 0);
        chk("R9", "rd addr", int'(mem_addr), int'(hl));
        chk("R9", "early done", int'(done), 0);
        @(negedge clk);
        start = 1'b0;
        chk("R9", "wr_en", int'(mem_wr_en), 1);
        chk("R9", "rd_en in write", int'(mem_rd_en), 0);
        chk(poke ? "R11" : "R9", "wr addr", int'(mem_addr), int'(hl));
        chk(poke ? "R11" : "R9", "wdata", int'(mem_wdata), r);
        @(negedge clk);
        chk("R9", "done", int'(done), 1);
        chk("R9", "wr_en in done", int'(mem_wr_en), 0);
        chk("R9", "write count", wr_count, 1);
        chk("R9", "mem byte", int'(mem[hl[7:0]]), r);
        check_flags(poke ? "R11" : op_req(op), r, c);
        @(negedge clk);
        chk(poke ? "R11" : "R9", "done after", int'(done), 0);
        chk(poke ? "R11" : "R9", "busy after", int'(busy), 0);
        chk("R9", "write count end", wr_count, 1);
    endtask

    task automatic run_reject(input logic [7:0] opc);
        logic [7:0] r0;
        logic z0, c0;
        r0 = result; z0 = flag_z; c0 = flag_c;
        wr_count = 0;
        @(negedge clk);
        opcode = opc; acc_in = 8'h3C; hl_in = 16'h0010; carry_in = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "mem access", int'(mem_rd_en | mem_wr_en), 0);
        @(negedge clk);
        chk("R10", "done", int'(done), 0);
        chk("R10", "result", int'(result), int'(r0));
        chk("R10", "flags", int'({flag_z, flag_c}), int'({z0, c0}));
        chk("R10", "writes", wr_count, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] pats [0:5];
        pats[0] = 8'h81; pats[1] = 8'h00; pats[2] = 8'h5A;
        pats[3] = 8'h80; pats[4] = 8'h01; pats[5] = 8'hF0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "done in reset", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "mem enables", int'(mem_rd_en | mem_wr_en), 0);
        chk("R1", "result", int'(result), 0);
        chk("R1", "flags", int'({flag_z, flag_n, flag_h, flag_c}), 0);

        // R2: accumulator opcodes 0x07..0x3F in steps of 8
        for (int op = 0; op < 8; op++)
            for (int p = 0; p < 6; p++)
                for (int ci = 0; ci < 2; ci++)
                    run_acc(op, pats[p], ci[0]);

        // R9: memory form for every operation
        for (int op = 0; op < 8; op++)
            for (int p = 0; p < 6; p++)
                run_mem(op, 16'h1200 + 16'(op * 8 + p), pats[p], p[0], 1'b0);

        // R11: start while busy is ignored
        run_mem(2, 16'h00A0, 8'h80, 1'b1, 1'b1);
        run_mem(6, 16'h00B0, 8'h12, 1'b0, 1'b1);

        // R10: rejected opcodes
        run_acc(5, 8'h81, 1'b0);
        run_reject(8'h00);
        run_reject(8'h3D);
        run_reject(8'h47);
        run_reject(8'hC6);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule